// File: doc/BRIEF.md
# Paged External Data RAM

This block is a 2 KB byte-wide data RAM that sits in the 64 KB external data address space of an 8-bit microcontroller core. The core reaches it in one of two ways. A wide access carries a full 16-bit pointer. A short access carries only an 8-bit operand, and the block supplies the upper address byte from a small page register.

Only the low 11 address bits select a location. The RAM therefore repeats every 2 KB across the whole 64 KB space, and a fill loop that walks a pointer upward wraps back to location 0 by itself. The page register sits on the special function register bus at address 0xAA. Its 3-bit field picks one of eight 256-byte pages for short accesses.

Top module: `xram_pager`

## Requirements
- R1: The RAM holds 2048 bytes. A read request (req_valid=1, req_we=0) accepted at a clock edge presents the addressed byte on rd_data after that edge. rd_data keeps its value on every cycle that carries no read, and it resets to 0x00.
- R2: A write request (req_valid=1, req_we=1) stores req_wdata at the clock edge where it is presented, and every one of the 2048 locations can be written.
- R3: In wide mode (req_short=0), the location is req_addr[10:0]. Bits 15 to 11 are ignored, so a location is seen at all 32 aliases spaced 0x0800 apart.
- R4: In short mode (req_short=1), the location is page*256 + req_addr[7:0], with page in bits 10 to 8. req_addr[15:8] is ignored. For example, with page 1, operands 0x00 to 0xFF reach locations 0x0100 to 0x01FF.
- R5: An SFR write (sfr_we=1) to sfr_addr 0xAA loads the page from sfr_wdata[2:0] and discards sfr_wdata[7:3]. An SFR write to any other address leaves the page unchanged.
- R6: An SFR read at address 0xAA returns {5'b00000, page}. Bits 7 to 3 always read as zero. Any other SFR address reads as 0x00.
- R7: After reset the page is 0, so the register reads as 0x00.
- R8: If a page write and a short access happen in the same cycle, the access uses the old page. The new page applies from the next cycle.
- R9: A sequence of wide writes at rising addresses that crosses 0x07FF continues at location 0x000, and no error is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_short | input | 1 | 1 = 8-bit operand with page, 0 = 16-bit pointer |
| req_addr | input | 16 | Access address; only bits 7:0 are used in short mode |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid one cycle after a read |
| sfr_addr | input | 8 | SFR bus address |
| sfr_we | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data (combinational) |

## Verification
The bench fills the whole RAM and then reads all 65536 wide addresses. A design that decoded any of bits 15 to 11 would return wrong bytes at the aliases. It also sweeps every page and operand, with changing junk in the operand's upper byte, to catch a page field placed at the wrong bits or a leak of req_addr[15:8]. Two tests target the edges of the page register: a page write made in the same cycle as a short write, which catches a bypass that applies the new page too early, and 0xFF written to the register, which must read back as 0x07. A write run across 0x07FF checks the wrap. A design with an extra address bit would place the tail of that run at 0x800 and leave location 0 untouched.

// File: rtl/xram_pager.sv
module xram_pager #(
  parameter int ADDR_BITS = 11,
  parameter int DATA_BITS = 8,
  parameter int SFR_BITS  = 8,
  parameter logic [7:0] PAGE_SFR = 8'hAA
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_we,
  input  logic                 req_short,
  input  logic [15:0]          req_addr,
  input  logic [DATA_BITS-1:0] req_wdata,
  output logic [DATA_BITS-1:0] rd_data,
  input  logic [7:0]           sfr_addr,
  input  logic                 sfr_we,
  input  logic [SFR_BITS-1:0]  sfr_wdata,
  output logic [SFR_BITS-1:0]  sfr_rdata
);
  localparam int DEPTH     = 1 << ADDR_BITS;
  localparam int PAGE_BITS = ADDR_BITS - 8;

  logic [DATA_BITS-1:0] mem [DEPTH];
  logic [PAGE_BITS-1:0] page;
  logic [ADDR_BITS-1:0] idx;
  logic                 page_hit;

  assign page_hit  = (sfr_addr == PAGE_SFR);
  assign idx       = req_short ? {page, req_addr[7:0]} : req_addr[ADDR_BITS-1:0];
  assign sfr_rdata = page_hit ? {{(SFR_BITS-PAGE_BITS){1'b0}}, page} : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) page <= '0;
    else if (sfr_we && page_hit) page <= sfr_wdata[PAGE_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (req_valid && req_we) mem[idx] <= req_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (req_valid && !req_we) rd_data <= mem[idx];
  end

  p_page_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && sfr_addr == PAGE_SFR) |=> (page == $past(sfr_wdata[PAGE_BITS-1:0])));

  p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sfr_we && sfr_addr == PAGE_SFR) |=> $stable(page));

  p_rd_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> $stable(rd_data));

  always_comb begin
    if (rst_n && sfr_addr == PAGE_SFR)
      p_sfr_upper_zero_r6: assert (sfr_rdata[SFR_BITS-1:PAGE_BITS] == '0);
    if (rst_n && sfr_addr != PAGE_SFR)
      p_sfr_other_zero_r6: assert (sfr_rdata == '0);
  end
endmodule

// File: tb/xram_pager_tb_top.sv
module xram_pager_tb_top;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, req_short = 0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0, rd_data;
  logic [7:0] sfr_addr = '0, sfr_wdata = '0, sfr_rdata;
  logic sfr_we = 0;
  int total = 0, bad = 0;
  logic [7:0] model [2048];

  always #2 clk = ~clk;

  xram_pager dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_short(req_short), .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
    .sfr_addr(sfr_addr), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [15:0] a, input logic [7:0] d, input logic [10:0] loc);
    req_valid = 1; req_we = 1; req_short = s; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_we = 0;
    model[loc] = d;
  endtask

  task automatic rd(input logic s, input logic [15:0] a, input logic [7:0] exp, input string req);
    req_valid = 1; req_we = 0; req_short = s; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(req, rd_data, exp);
  endtask

  task automatic set_page(input logic [7:0] v);
    sfr_addr = 8'hAA; sfr_wdata = v; sfr_we = 1;
    @(negedge clk);
    sfr_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    sfr_addr = 8'hAA; #1;
    chk("R7 page after reset", sfr_rdata, 8'h00);
    chk("R1 rd_data reset", rd_data, 8'h00);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 2048; i++)
      wr(0, 16'(i), 8'((i * 7) ^ (i >> 8) ^ 8'h5A), 11'(i));

    for (int a = 0; a < 65536; a++)
      rd(0, 16'(a), model[a[10:0]], "R3 wide alias read");

    for (int p = 0; p < 8; p++) begin
      set_page(8'(p) | 8'hA8);
      sfr_addr = 8'hAA; #1;
      chk("R5 page load masks upper bits", sfr_rdata, 8'(p));
      for (int op = 0; op < 256; op++)
        rd(1, {8'((op * 29) + p), 8'(op)}, model[{3'(p), 8'(op)}], "R4 short paged read");
    end

    set_page(8'h06);
    for (int op = 0; op < 256; op++)
      wr(1, {8'(op ^ 8'h3C), 8'(op)}, 8'(op + 8'h11), {3'd6, 8'(op)});
    for (int op = 0; op < 256; op++)
      rd(0, {5'b10101, 3'd6, 8'(op)}, 8'(op + 8'h11), "R2 short write seen via wide");

    set_page(8'hFF);
    sfr_addr = 8'hAA; #1;
    chk("R6 upper bits read zero", sfr_rdata, 8'h07);
    sfr_addr = 8'hAB; sfr_wdata = 8'h02; sfr_we = 1;
    #1 chk("R6 other SFR reads zero", sfr_rdata, 8'h00);
    @(negedge clk); sfr_we = 0;
    sfr_addr = 8'hAA; #1;
    chk("R5 other SFR write ignored", sfr_rdata, 8'h07);

    set_page(8'h02);
    sfr_addr = 8'hAA; sfr_wdata = 8'h05; sfr_we = 1;
    req_valid = 1; req_we = 1; req_short = 1; req_addr = 16'h0033; req_wdata = 8'hC4;
    @(negedge clk);
    sfr_we = 0; req_valid = 0; req_we = 0;
    held = model[11'h533];
    model[11'h233] = 8'hC4;
    rd(0, 16'h0233, 8'hC4, "R8 same-cycle write used old page");
    rd(0, 16'h0533, held, "R8 new page location untouched");
    sfr_addr = 8'hAA; #1;
    chk("R8 new page applied after", sfr_rdata, 8'h05);
    rd(1, 16'hFF33, model[11'h533], "R8 next access uses new page");

    held = rd_data;
    @(negedge clk);
    chk("R1 rd_data holds idle", rd_data, held);
    wr(0, 16'h0100, 8'h99, 11'h100);
    chk("R1 rd_data holds on write", rd_data, held);

    for (int k = 0; k < 32; k++)
      wr(0, 16'(16'h07F0 + k), 8'(8'hE0 + k), 11'(11'h7F0 + k));
    for (int k = 0; k < 32; k++)
      rd(0, 16'(16'h07F0 + k) & 16'h07FF | 16'h0000, 8'(8'hE0 + k), "R9 linear fill wraps");
    rd(0, 16'h0000, 8'hF0, "R9 location 0 holds wrapped byte");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule